// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the head of a receive path and judges each incoming frame by its destination address alone. Bytes arrive one per cycle on a valid/start-of-frame interface. The first six bytes after a start marker form the destination address. A CRC-32 over those bytes is folded in one byte per cycle. A compare against the station address and a broadcast test run alongside it. When the sixth byte has been taken, the block issues one decision strobe. The strobe says whether the frame should be kept and whether its destination was a group address.

Three bits of a receive configuration input control reception. One accepts every frame. One admits the all-ones broadcast address. One admits multicast frames, which must also hit a 64-bin hash table. The station address and the hash table are byte registers written by the host through a simple write port. Rejected frames produce no accept pulse, so a downstream writer that gates on the accept output makes no write for them.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that takes the sixth destination byte of a frame. It is low at every other time.
- R2: When `rx_cfg` bit 4 is set at the sixth byte, the frame is accepted whatever its destination.
- R3: A destination of six 0xFF bytes is a broadcast. When bit 4 is clear, a broadcast is accepted exactly when `rx_cfg` bit 2 is set.
- R4: A destination that is not a broadcast and whose first byte has bit 0 set is multicast. When bits 4 and 3 are both clear, a multicast frame is rejected.
- R5: For a multicast frame with bit 3 set and bit 4 clear, a CRC-32 is computed over the six bytes in arrival order. The CRC uses polynomial 0x04C11DB7 and starts from all ones. It shifts left and feeds each byte least significant bit first. CRC bits 31..26 form an index k. The frame is accepted exactly when bit (k mod 8) of hash byte (k div 8) is 1.
- R6: When bit 4 is clear, a destination whose first byte has bit 0 clear is accepted exactly when destination byte n equals station byte n for every n from 0 to 5.
- R7: A write with `reg_we` high loads `reg_wdata` into one byte. Addresses 0..5 are station bytes 0..5, where byte 0 is compared with the first destination byte. Addresses 8..15 are hash bytes 0..7. Writes to addresses 6 and 7 change nothing.
- R8: `dec_accept` and `dec_group` are 0 whenever `dec_valid` is 0. With `dec_valid`, `dec_group` equals bit 0 of the first destination byte.
- R9: Bytes after the sixth are ignored until the next start marker. A start marker that arrives before six bytes have been taken discards the partial address and restarts at byte 0.
- R10: After reset `dec_valid` is 0 and every station and hash byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 accept all |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_sof | input | 1 | The present byte is the first of a frame |
| in_data | input | 8 | Frame byte |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host register write data |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Destination is a group address |

## Verification
The assertions take for granted that `in_sof` is only raised together with `in_valid`. They also take `rx_cfg` as meaningful only in the cycle of the sixth byte, because that is when it is sampled. The gating properties therefore tie the configuration seen at that byte to the accept bit one cycle later. The stimulus drives the start marker only on valid bytes and holds the configuration steady across each frame. It mixes random frames with matching, near-miss, broadcast and multicast destinations. Directed cases cover hash-bit isolation, trailing bytes, restarted addresses and the unmapped register holes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          OCTET_W     = 8;
    localparam int          CFG_BCAST   = 2;
    localparam int          CFG_MCAST   = 3;
    localparam int          CFG_PROMISC = 4;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;

    // Per-frame address summary handed from the collector to the decision stage
    typedef struct packed {
        logic       last;    // sixth destination byte taken this cycle
        logic       group;   // first byte had bit 0 set
        logic       bcast;   // all six bytes were 0xFF
        logic       sta_eq;  // all six bytes matched the station address
        logic [5:0] hidx;    // top CRC bits
    } addr_summary_t;

    // One byte through the CRC register, least significant data bit first
    function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  octet);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < OCTET_W; b++) begin
            fb = c[31] ^ octet[b];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
#(
    parameter int STA_BYTES  = 6,
    parameter int HASH_BYTES = 8,
    parameter int AW         = 4,
    parameter int HASH_BASE  = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reg_we,
    input  logic [AW-1:0]                       reg_addr,
    input  logic [OCTET_W-1:0]                  reg_wdata,
    output logic [STA_BYTES-1:0][OCTET_W-1:0]   sta_q,
    output logic [HASH_BYTES-1:0][OCTET_W-1:0]  hash_q
);

    for (genvar i = 0; i < STA_BYTES; i++) begin : g_sta
        always_ff @(posedge clk) begin
            if (rst)
                sta_q[i] <= '0;
            else if (reg_we && reg_addr == AW'(i))
                sta_q[i] <= reg_wdata;
        end
    end

    for (genvar j = 0; j < HASH_BYTES; j++) begin : g_hash
        always_ff @(posedge clk) begin
            if (rst)
                hash_q[j] <= '0;
            else if (reg_we && reg_addr == AW'(HASH_BASE + j))
                hash_q[j] <= reg_wdata;
        end
    end

    // R7: addresses in the hole between the station bytes and the table touch nothing
    p_hole_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr >= AW'(STA_BYTES) && reg_addr < AW'(HASH_BASE))
        |=> ($stable(sta_q) && $stable(hash_q)));

endmodule

// File: rtl/rxf_collect.sv
module rxf_collect
    import rxf_pkg::*;
#(
    parameter int STA_BYTES = 6,
    parameter int HASH_BITS = 6,
    localparam int PW       = $clog2(STA_BYTES + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic                              in_sof,
    input  logic [OCTET_W-1:0]                in_data,
    input  logic [STA_BYTES-1:0][OCTET_W-1:0] sta_q,
    output addr_summary_t                     summ
);

    logic [PW-1:0]     pos_q;     // bytes taken; STA_BYTES means idle
    logic [31:0]       crc_q;
    logic              grp_q, ones_q, eq_q;

    logic [PW-1:0]     eff_pos;
    logic              take;
    logic [31:0]       crc_nx;
    logic              ones_nx, eq_nx, grp_nx;
    logic [OCTET_W-1:0] sta_sel;

    always_comb begin
        eff_pos = in_sof ? '0 : pos_q;
        take    = in_valid && (in_sof || pos_q < PW'(STA_BYTES));
        sta_sel = (eff_pos < PW'(STA_BYTES)) ? sta_q[eff_pos] : '0;
        crc_nx  = crc_step_byte(in_sof ? CRC_SEED : crc_q, in_data);
        ones_nx = (in_sof ? 1'b1 : ones_q) & (in_data == 8'hFF);
        eq_nx   = (in_sof ? 1'b1 : eq_q) & (in_data == sta_sel);
        grp_nx  = (eff_pos == '0) ? in_data[0] : grp_q;

        summ.last   = take && (eff_pos == PW'(STA_BYTES - 1));
        summ.group  = grp_nx;
        summ.bcast  = ones_nx;
        summ.sta_eq = eq_nx;
        summ.hidx   = '0;
        summ.hidx[HASH_BITS-1:0] = crc_nx[31 -: HASH_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= PW'(STA_BYTES);
            crc_q  <= CRC_SEED;
            grp_q  <= 1'b0;
            ones_q <= 1'b0;
            eq_q   <= 1'b0;
        end else if (take) begin
            pos_q  <= eff_pos + 1'b1;
            crc_q  <= crc_nx;
            grp_q  <= grp_nx;
            ones_q <= ones_nx;
            eq_q   <= eq_nx;
        end
    end

    // R9: the position counter stops at the idle value
    p_pos_bound_r9: assert property (@(posedge clk) disable iff (rst)
        pos_q <= PW'(STA_BYTES));

    // R9: a start marker always restarts the address at its first byte
    p_sof_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> (pos_q == PW'(1)));

    // R9: once idle, unmarked bytes leave the collector idle
    p_trail_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (pos_q == PW'(STA_BYTES) && !in_sof) |=> (pos_q == PW'(STA_BYTES)));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int HASH_BITS  = 6,
    localparam int HASH_BYTES = (2 ** HASH_BITS) / OCTET_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  addr_summary_t                      summ,
    input  logic [OCTET_W-1:0]                 rx_cfg,
    input  logic [HASH_BYTES-1:0][OCTET_W-1:0] hash_q,
    output logic                               dec_valid,
    output logic                               dec_accept,
    output logic                               dec_group
);

    logic hash_hit;
    logic accept_c;

    always_comb begin
        hash_hit = hash_q[summ.hidx[HASH_BITS-1:3]][summ.hidx[2:0]];
        if (rx_cfg[CFG_PROMISC])
            accept_c = 1'b1;
        else if (summ.bcast)
            accept_c = rx_cfg[CFG_BCAST];
        else if (summ.group)
            accept_c = rx_cfg[CFG_MCAST] && hash_hit;
        else
            accept_c = summ.sta_eq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
        end else begin
            dec_valid  <= summ.last;
            dec_accept <= summ.last && accept_c;
            dec_group  <= summ.last && summ.group;
        end
    end

    // R1: decisions never come back to back
    p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R2: accept-all wins over every other test
    p_promisc_r2: assert property (@(posedge clk) disable iff (rst)
        (summ.last && rx_cfg[CFG_PROMISC]) |=> (dec_valid && dec_accept));

    // R3: broadcast is refused without its enable
    p_bcast_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (summ.last && summ.bcast && !rx_cfg[CFG_PROMISC] && !rx_cfg[CFG_BCAST])
        |=> !dec_accept);

    // R4: multicast is refused without its enable
    p_mcast_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (summ.last && summ.group && !summ.bcast &&
         !rx_cfg[CFG_PROMISC] && !rx_cfg[CFG_MCAST]) |=> !dec_accept);

    // R6: a unicast miss is refused
    p_unicast_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (summ.last && !summ.group && !rx_cfg[CFG_PROMISC] && !summ.sta_eq)
        |=> !dec_accept);

    // R8: result bits are quiet outside the strobe
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_accept && !dec_group));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int STA_BYTES = 6,
    parameter int HASH_BITS = 6,
    parameter int AW        = 4,
    parameter int HASH_BASE = 8,
    localparam int HASH_BYTES = (2 ** HASH_BITS) / OCTET_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_cfg,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_data,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_group
);

    logic [STA_BYTES-1:0][OCTET_W-1:0]  sta_q;
    logic [HASH_BYTES-1:0][OCTET_W-1:0] hash_q;
    addr_summary_t                      summ;

    rxf_regs #(
        .STA_BYTES (STA_BYTES),
        .HASH_BYTES(HASH_BYTES),
        .AW        (AW),
        .HASH_BASE (HASH_BASE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sta_q    (sta_q),
        .hash_q   (hash_q)
    );

    rxf_collect #(
        .STA_BYTES(STA_BYTES),
        .HASH_BITS(HASH_BITS)
    ) u_collect (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_data (in_data),
        .sta_q   (sta_q),
        .summ    (summ)
    );

    rxf_decide #(
        .HASH_BITS(HASH_BITS)
    ) u_decide (
        .clk       (clk),
        .rst       (rst),
        .summ      (summ),
        .rx_cfg    (rx_cfg),
        .hash_q    (hash_q),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept),
        .dec_group (dec_group)
    );

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_cfg = '0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       dec_valid, dec_accept, dec_group;

    int checks = 0;
    int errors = 0;

    logic [7:0] sta_m  [6];
    logic [7:0] hash_m [8];

    always #5 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst(rst), .rx_cfg(rx_cfg),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_group(dec_group)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_index(input logic [7:0] d [6]);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 8; b++) begin
                logic top = r[31];
                r = r << 1;
                if (top != d[i][b]) r = r ^ 32'h04C1_1DB7;
            end
        return r[31:26];
    endfunction

    function automatic logic ref_accept(input logic [7:0] d [6], input logic [7:0] cfg);
        logic all_ff = 1'b1;
        logic same = 1'b1;
        logic [5:0] k;
        for (int i = 0; i < 6; i++) begin
            if (d[i] != 8'hFF) all_ff = 1'b0;
            if (d[i] != sta_m[i]) same = 1'b0;
        end
        k = ref_index(d);
        if (cfg[4]) return 1'b1;
        if (all_ff) return cfg[2];
        if (d[0][0]) return cfg[3] && hash_m[k[5:3]][k[2:0]];
        return same;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < 4'd6) sta_m[a] = v;
        else if (a >= 4'd8) hash_m[a - 4'd8] = v;
    endtask

    // Drives six address bytes plus optional trailing bytes, checks the strobe cycle and the quiet cycles
    task automatic frame(input logic [7:0] d [6], input logic [7:0] cfg, input int extra, input string req);
        logic exp_acc = ref_accept(d, cfg);
        rx_cfg = cfg;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1 no early strobe", dec_valid, 1'b0);
            in_valid = 1'b1; in_sof = (i == 0); in_data = d[i];
        end
        @(negedge clk);
        in_sof = 1'b0;
        if (extra > 0) in_data = 8'hA5; else in_valid = 1'b0;
        chk("R1 strobe", dec_valid, 1'b1);
        chk(req, dec_accept, exp_acc);
        chk("R8 group bit", dec_group, d[0][0]);
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            if (e == extra - 1) in_valid = 1'b0;
            chk("R9 trailing byte ignored", dec_valid, 1'b0);
            chk("R8 accept quiet", dec_accept, 1'b0);
        end
        @(negedge clk);
        chk("R1 single cycle", dec_valid, 1'b0);
        chk("R8 accept quiet", dec_accept, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d [6];
        logic [5:0] k;
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        for (int i = 0; i < 6; i++) sta_m[i] = 8'h00;
        for (int i = 0; i < 8; i++) hash_m[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 strobe low after reset", dec_valid, 1'b0);
        chk("R10 accept low after reset", dec_accept, 1'b0);

        // R10: zeroed station matches an all-zero destination
        for (int i = 0; i < 6; i++) d[i] = 8'h00;
        frame(d, 8'h00, 0, "R10 station reset to zero");

        // R5: zeroed table refuses multicast even when enabled
        d = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
        frame(d, 8'h08, 0, "R10 hash reset to zero (R5)");

        for (int i = 0; i < 6; i++) wr(4'(i), 8'h10 + 8'(i * 17));
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        frame(d, 8'h00, 0, "R6 station match");
        d[5] = d[5] ^ 8'h40;
        frame(d, 8'h00, 0, "R6 last byte miss");
        frame(d, 8'h10, 0, "R2 accept all on miss");

        // R7: unmapped addresses leave the station intact
        wr(4'd6, 8'hEE);
        wr(4'd7, 8'h77);
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        frame(d, 8'h00, 0, "R7 hole writes ignored");

        for (int i = 0; i < 6; i++) d[i] = 8'hFF;
        frame(d, 8'h00, 0, "R3 broadcast disabled");
        frame(d, 8'h04, 0, "R3 broadcast enabled");
        frame(d, 8'h08, 0, "R3 broadcast not taken as multicast");

        d = '{8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hFB};
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'hFF);
        frame(d, 8'h00, 0, "R4 multicast disabled");
        frame(d, 8'h08, 0, "R5 full table hit");
        k = ref_index(d);
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'h00);
        wr(4'(8 + k[5:3]), 8'h01 << k[2:0]);
        frame(d, 8'h08, 0, "R5 single bin hit");
        wr(4'(8 + k[5:3]), ~(8'h01 << k[2:0]));
        for (int i = 0; i < 8; i++) if (i != int'(k[5:3])) wr(4'(8 + i), 8'hFF);
        frame(d, 8'h08, 0, "R5 all bins but one");

        // R9: trailing bytes after the address
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        frame(d, 8'h00, 5, "R9 frame with trailing bytes");

        // R9: restart part way through an address
        rx_cfg = 8'h00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_data = 8'hFF;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        chk("R9 partial address gives no strobe", dec_valid, 1'b0);
        frame(d, 8'h00, 0, "R9 restart after partial address");

        // Random frames
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'($urandom));
        for (int n = 0; n < 300; n++) begin
            int kind = int'($urandom % 4);
            logic [7:0] cfg = 8'($urandom) & 8'h1C;
            for (int i = 0; i < 6; i++) d[i] = 8'($urandom);
            case (kind)
                0: begin
                    for (int i = 0; i < 6; i++) d[i] = sta_m[i];
                    if ($urandom % 2) d[$urandom % 6] ^= 8'h02;
                end
                1: for (int i = 0; i < 6; i++) d[i] = 8'hFF;
                2: d[0][0] = 1'b1;
                default: ;
            endcase
            frame(d, cfg, int'($urandom % 3), "R2 R3 R4 R5 R6 random frame");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule